// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks a page frame to evict using the clock (second-chance) policy. It keeps one reference bit for each of `NUM_FRAMES` frames and a circular hand that points at the next frame to examine. Each bit of the per-frame access vector marks its frame as recently used. Until an eviction is requested, nothing else happens.

When the eviction request is taken, the hand starts a sweep and examines one frame per clock. A frame whose bit is set loses the bit and is skipped. The first frame found with a clear bit becomes the victim. Its index is presented for exactly one cycle together with a valid pulse, and the hand moves to the frame after it. Surrounding logic loads the new page and updates the tables. If every bit is set, one full lap clears them all and the frame where the sweep began is chosen. In that case the policy reduces to first-in-first-out.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all reference bits are 0, the hand points to frame 0, and `victim_valid_o` is 0. The first request therefore returns frame 0.
- R2: A 1 on `touch_i[k]` at a rising edge sets the reference bit of frame k. Several frames may be marked in the same cycle.
- R3: Without an accepted eviction request, no reference bit is cleared, the hand does not move, and `victim_valid_o` stays 0.
- R4: During a sweep, a frame whose bit is 1 has the bit cleared and is passed over. This takes one cycle.
- R5: The sweep stops at the first examined frame whose bit is 0. It then drives `victim_valid_o` high for exactly one cycle with `victim_idx_o` set to that frame. With k frames skipped, the pulse is visible k+1 cycles after the edge that accepted the request.
- R6: The hand visits frames in increasing order and wraps from frame `NUM_FRAMES-1` to frame 0.
- R7: If all bits are set when a sweep starts, every bit is cleared and the starting frame is selected after `NUM_FRAMES`+1 sweep cycles.
- R8: After a selection the hand points at the frame after the victim, and the victim's bit stays 0 unless that frame is accessed.
- R9: Accesses during a sweep still set bits. If an access and a sweep clear hit the same frame in the same cycle, the bit ends up set.
- R10: An eviction request that arrives while a sweep is in progress is ignored. It does not queue a second sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_i | input | NUM_FRAMES | One access bit per frame; sets that frame's reference bit |
| evict_req_i | input | 1 | Request a victim; taken only while no sweep is running |
| victim_valid_o | output | 1 | One-cycle pulse marking a selected victim |
| victim_idx_o | output | $clog2(NUM_FRAMES) | Index of the selected victim frame |

## Verification
The bench measures the latency of each request, so a design that skips frames incorrectly, fails to clear bits, or examines more than one frame per cycle returns the wrong index or arrives on the wrong cycle. Wraparound from the top frame and the all-set lap, which must take N+1 cycles and return the starting frame, catch a hand that saturates or a sweep that never ends. An access that collides with a clear on the same frame is revealed on a later lap: if the clear wins, the frame is wrongly chosen there. A request issued in the middle of a sweep must not start a second sweep. A design that queued it would emit an extra pulse and shift the hand.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/clock_ref_bits.sv
module clock_ref_bits #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] set_i,
    input  logic                  clr_en_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    output logic [NUM_FRAMES-1:0] bits_o
);
    logic [NUM_FRAMES-1:0] bits_d, bits_q;

    // Per-frame next state: an access wins over a sweep clear
    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
        logic clr_here;
        always_comb begin
            clr_here  = clr_en_i && (clr_idx_i == IDX_W'(k));
            bits_d[k] = set_i[k] | (bits_q[k] & ~clr_here);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [IDX_W-1:0] hand_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    logic [IDX_W-1:0] hand_d, hand_q;

    always_comb begin
        hand_d = hand_q;
        if (step_i) hand_d = (hand_q == LAST) ? '0 : hand_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hand_q <= '0;
        else        hand_q <= hand_d;
    end

    assign hand_o = hand_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
    import clock_sel_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] touch_i,
    input  logic                  evict_req_i,
    output logic                  victim_valid_o,
    output logic [IDX_W-1:0]      victim_idx_o
);
    typedef struct packed {
        sweep_state_e     state;
        logic             found;
        logic [IDX_W-1:0] victim;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_FRAMES-1:0] ref_q;
    logic [IDX_W-1:0]      hand_q;
    logic                  step;
    logic                  clr_en;
    logic                  sweep_act;

    clock_ref_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (touch_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (hand_q),
        .bits_o    (ref_q)
    );

    clock_hand #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .hand_o (hand_q)
    );

    assign sweep_act = (ctl_q.state == ST_SWEEP);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.found = 1'b0;
        step        = 1'b0;
        clr_en      = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (evict_req_i) ctl_d.state = ST_SWEEP;
            end
            ST_SWEEP: begin
                // requests are not looked at here: a running sweep absorbs them
                step = 1'b1;
                if (ref_q[hand_q]) begin
                    clr_en = 1'b1;
                end else begin
                    ctl_d.found  = 1'b1;
                    ctl_d.victim = hand_q;
                    ctl_d.state  = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.found  <= 1'b0;
            ctl_q.victim <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign victim_valid_o = ctl_q.found;
    assign victim_idx_o   = ctl_q.victim;
endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FRAMES-1:0] touch_i,
    input logic                  victim_valid_o,
    input logic [IDX_W-1:0]      victim_idx_o,
    input logic [NUM_FRAMES-1:0] ref_q,
    input logic [IDX_W-1:0]      hand_q,
    input logic                  sweep_act
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    logic [NUM_FRAMES-1:0] touch_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) touch_prev <= '0;
        else        touch_prev <= touch_i;
    end

    // R2 / R9: an access always leaves its bit set
    p_touch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|touch_i) |=> ((ref_q & $past(touch_i)) == $past(touch_i)));

    // R3: nothing is cleared outside a sweep
    p_idle_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_act |=> (($past(ref_q) & ~ref_q) == '0));

    // R3: the hand holds still outside a sweep
    p_idle_hand_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_act |=> $stable(hand_q));

    // R5: the valid pulse lasts one cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |=> !victim_valid_o);

    // R8: the hand sits one past the victim
    p_hand_past_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |-> (hand_q == ((victim_idx_o == LAST) ? '0 : victim_idx_o + 1'b1)));

    // R8: the victim's bit is clear unless it was just accessed
    p_victim_bit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |-> (!ref_q[victim_idx_o] || touch_prev[victim_idx_o]));
endmodule

bind clock_victim_sel clock_victim_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .touch_i        (touch_i),
    .victim_valid_o (victim_valid_o),
    .victim_idx_o   (victim_idx_o),
    .ref_q          (ref_q),
    .hand_q         (hand_q),
    .sweep_act      (sweep_act)
);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
    localparam int N = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  touch_i = '0;
    logic          evict_req_i = 1'b0;
    logic          victim_valid_o;
    logic [IW-1:0] victim_idx_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .touch_i        (touch_i),
        .evict_req_i    (evict_req_i),
        .victim_valid_o (victim_valid_o),
        .victim_idx_o   (victim_idx_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic touch(input logic [N-1:0] mask);
        @(negedge clk); touch_i = mask;
        @(negedge clk); touch_i = '0;
    endtask

    // Request once; mid_mask is driven during the first sweep cycle,
    // extra raises a second request two cycles into the sweep.
    task automatic evict_check(input string req, input int exp_idx, input int exp_lat,
                               input logic [N-1:0] mid_mask, input bit extra);
        int lat = 0;
        @(negedge clk); evict_req_i = 1'b1;
        @(negedge clk); evict_req_i = 1'b0; touch_i = mid_mask;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            touch_i = '0;
            evict_req_i = (lat == 2) ? extra : 1'b0;
            if (victim_valid_o) break;
        end
        evict_req_i = 1'b0;
        chk({req, " victim index"}, int'(victim_idx_o), exp_idx);
        chk({req, " latency"}, lat, exp_lat);
    endtask

    task automatic quiet_check(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (victim_valid_o) seen++;
        end
        chk({req, " no victim pulse"}, seen, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid low after reset", int'(victim_valid_o), 0);
        evict_check("R1 first victim", 0, 1, '0, 1'b0);
    endtask

    task automatic t_skip();                 // hand at 1
        touch(8'b0000_0110);
        evict_check("R4 R5 skip set frames", 3, 3, '0, 1'b0);
        quiet_check("R5 one-cycle pulse", 1);
    endtask

    task automatic t_idle();                 // hand at 4
        quiet_check("R3 idle", 6);
        evict_check("R3 hand unmoved while idle", 4, 1, '0, 1'b0);
    endtask

    task automatic t_wrap();                 // hand at 5
        touch(8'b1110_0000);
        evict_check("R6 wrap to frame 0", 0, 4, '0, 1'b0);
    endtask

    task automatic t_all_set();              // hand at 1
        touch('1);
        evict_check("R7 all set selects start", 1, N + 1, '0, 1'b0);
        evict_check("R7 R4 bits cleared by lap", 2, 1, '0, 1'b0);
    endtask

    task automatic t_lap();                  // hand at 3
        for (int i = 0; i < N + 1; i++)
            evict_check("R8 next frame, victim bit stays 0", (3 + i) % N, 1, '0, 1'b0);
    endtask

    task automatic t_access_in_sweep();      // hand at 4
        touch(8'b0011_0000);
        evict_check("R9 access during sweep", 7, 4, 8'b0101_0000, 1'b0);
        for (int f = 0; f < 4; f++)
            evict_check("R9 plain frames", f, 1, '0, 1'b0);
        evict_check("R9 access beats clear", 5, 2, '0, 1'b0);
    endtask

    task automatic t_ignore_req();           // hand at 6
        touch(8'b1100_0000);
        evict_check("R10 sweep with extra request", 0, 3, '0, 1'b1);
        quiet_check("R10 extra request ignored", 5);
        evict_check("R10 hand after ignored request", 1, 1, '0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_skip();
        t_idle();
        t_wrap();
        t_all_set();
        t_lap();
        t_access_in_sweep();
        t_ignore_req();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule